// File: doc/BRIEF.md
# Host-Overridable Eight-State Sequencer

This block is a small programmable sequencer with eight states. A host reaches it through a simple register bus made of a write strobe, an address, write data and combinational read data. Through that bus the host reads the current state, forces the machine into any state, and rewrites the 8-bit output pattern that belongs to each state. The pattern output always shows the word stored for the state the machine is in, one clock after that state was entered.

Each state advances by itself according to a configuration table that arrives on an input port. For every state the table holds two transition entries. Each entry names one of eight condition inputs and a target state. The first entry has priority over the second. When neither named input is high, the machine stays where it is. A host write to the state register always wins over an automatic transition in the same cycle.

Top module: `forced_sequencer`

## Requirements
- R1: While rstN is low, the state is 0, every pattern register holds 0x00 and patternOut is 0x00.
- R2: Address 8 is the state register. A read returns the current state in bits 2..0 and zeros in bits 7..3. Bits 7..3 of a write are discarded.
- R3: Addresses 0 to 7 hold the output patterns for states 0 to 7, with address k belonging to state k. Each is writable at any time, and a read returns the last value written.
- R4: A write to address 8 sets the state to busWdata[2:0] at the next clock edge, even when a table transition is due in that same cycle.
- R5: For state s, table bits [12s+5:12s] form entry 0 and bits [12s+11:12s+6] form entry 1. In each entry, bits 2..0 select a condition input and bits 5..3 give the target state. If the input named by entry 0 is high, the next state is its target. Otherwise, if the input named by entry 1 is high, the next state is that entry's target.
- R6: If neither selected condition input is high and there is no state write, the state does not change.
- R7: patternOut is registered. At each clock edge it takes the pattern register value, as held before that edge, of the state that was current before that edge.
- R8: Addresses 9 to 15 read as 0x00. Writes to them change neither the state nor any pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 4 | Register address |
| busWdata | input | 8 | Register write data |
| busRdata | output | 8 | Combinational read data for busAddr |
| condIn | input | 8 | Condition inputs used by the transition table |
| cfgTable | input | 96 | Transition table, two 6-bit entries per state |
| patternOut | output | 8 | Registered pattern of the current state |

## Verification
The assertions assume the bus and condition inputs change only away from the rising clock edge. They also assume that rstN is released between edges. The stepping assertions rely on the table staying steady across the edge that uses it. The bench changes every input at the falling edge, including reset release, so each rising edge sees settled values. It keeps the table fixed across each random phase and changes it only in directed steps.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic stateWr;   // host write to the state register
    logic patWr;     // host write to a pattern register
    logic rdState;   // read selects the state register
    logic rdPat;     // read selects a pattern register
  } seqStrobe_t;
endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
#(
  parameter int NUM_STATES = 8,
  parameter int NUM_IN     = 8,
  parameter int ADDR_W     = 4,
  localparam int STATE_W   = $clog2(NUM_STATES),
  localparam int SEL_W     = $clog2(NUM_IN),
  localparam int ENTRY_W   = SEL_W + STATE_W,
  localparam int TBL_W     = NUM_STATES * 2 * ENTRY_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [STATE_W-1:0] wrState,
  input  logic [NUM_IN-1:0]  condIn,
  input  logic [TBL_W-1:0]   cfgTable,
  output seqStrobe_t         strb,
  output logic [STATE_W-1:0] curState
);
  localparam logic [ADDR_W-1:0] STATE_ADDR = ADDR_W'(NUM_STATES);

  logic [ENTRY_W-1:0] entry0, entry1;
  logic [SEL_W-1:0]   sel0, sel1;
  logic [STATE_W-1:0] tgt0, tgt1;

  always_comb begin
    strb.stateWr = busWr && (busAddr == STATE_ADDR);
    strb.patWr   = busWr && (busAddr < STATE_ADDR);
    strb.rdState = (busAddr == STATE_ADDR);
    strb.rdPat   = (busAddr < STATE_ADDR);
  end

  assign entry0 = cfgTable[int'(curState) * 2 * ENTRY_W +: ENTRY_W];
  assign entry1 = cfgTable[int'(curState) * 2 * ENTRY_W + ENTRY_W +: ENTRY_W];
  assign sel0   = entry0[SEL_W-1:0];
  assign tgt0   = entry0[ENTRY_W-1:SEL_W];
  assign sel1   = entry1[SEL_W-1:0];
  assign tgt1   = entry1[ENTRY_W-1:SEL_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               curState <= '0;
    else if (strb.stateWr)   curState <= wrState;
    else if (condIn[sel0])   curState <= tgt0;
    else if (condIn[sel1])   curState <= tgt1;
  end

  AST_RESET_ZERO: assert property (@(posedge clk) !rstN |=> curState == '0); // R1
  AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == STATE_ADDR) |=> curState == $past(wrState)); // R4
  AST_FIRST_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (!(busWr && busAddr == STATE_ADDR) && condIn[sel0]) |=> curState == $past(tgt0)); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!(busWr && busAddr == STATE_ADDR) && !condIn[sel0] && !condIn[sel1]) |=> $stable(curState)); // R6
endmodule

// File: rtl/fseq_dpath.sv
module fseq_dpath
  import fseq_pkg::*;
#(
  parameter int NUM_STATES = 8,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 4,
  localparam int STATE_W   = $clog2(NUM_STATES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strb,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [STATE_W-1:0] curState,
  output logic [DATA_W-1:0]  busRdata,
  output logic [DATA_W-1:0]  patternOut
);
  logic [DATA_W-1:0] patReg [NUM_STATES];

  for (genvar g = 0; g < NUM_STATES; g++) begin : gPat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                        patReg[g] <= '0;
      else if (strb.patWr && busAddr == ADDR_W'(g))     patReg[g] <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) patternOut <= '0;
    else       patternOut <= patReg[curState];
  end

  always_comb begin
    busRdata = '0;
    if (strb.rdState)    busRdata = DATA_W'(curState);
    else if (strb.rdPat) busRdata = patReg[busAddr[STATE_W-1:0]];
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdState |-> busRdata[DATA_W-1:STATE_W] == '0); // R2
  AST_OUT_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(curState) && !$past(strb.patWr)) |=> $stable(patternOut)); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr > ADDR_W'(NUM_STATES)) |-> busRdata == '0); // R8
endmodule

// File: rtl/forced_sequencer.sv
module forced_sequencer
  import fseq_pkg::*;
#(
  parameter int NUM_STATES = 8,
  parameter int NUM_IN     = 8,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 4,
  localparam int STATE_W   = $clog2(NUM_STATES),
  localparam int ENTRY_W   = $clog2(NUM_IN) + STATE_W,
  localparam int TBL_W     = NUM_STATES * 2 * ENTRY_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [NUM_IN-1:0] condIn,
  input  logic [TBL_W-1:0]  cfgTable,
  output logic [DATA_W-1:0] patternOut
);
  seqStrobe_t         strb;
  logic [STATE_W-1:0] curState;

  fseq_ctrl #(.NUM_STATES(NUM_STATES), .NUM_IN(NUM_IN), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .wrState(busWdata[STATE_W-1:0]), .condIn(condIn), .cfgTable(cfgTable),
    .strb(strb), .curState(curState)
  );

  fseq_dpath #(.NUM_STATES(NUM_STATES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr), .busWdata(busWdata),
    .curState(curState), .busRdata(busRdata), .patternOut(patternOut)
  );
endmodule

// File: tb/forced_sequencer_tb.sv
module forced_sequencer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [7:0]  condIn = '0;
  logic [95:0] cfgTable = '0;
  logic [7:0]  patternOut;

  always #10 clk = ~clk;

  forced_sequencer u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .condIn(condIn), .cfgTable(cfgTable), .patternOut(patternOut)
  );

  int nChecks = 0;
  int nFail = 0;
  logic [2:0] mState;
  logic [7:0] mPat [8];
  logic [7:0] mOut;

  function automatic logic [2:0] mNext(logic [2:0] s, logic [7:0] c, logic [95:0] t);
    logic [5:0] e0, e1;
    e0 = t[int'(s)*12 +: 6];
    e1 = t[int'(s)*12 + 6 +: 6];
    if (c[e0[2:0]])      return e0[5:3];
    else if (c[e1[2:0]]) return e1[5:3];
    return s;
  endfunction

  function automatic logic [7:0] mRead(logic [3:0] a);
    if (a < 4'd8)  return mPat[a[2:0]];
    if (a == 4'd8) return {5'b0, mState};
    return 8'h00;
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic setBus(logic wr, logic [3:0] a, logic [7:0] d);
    busWr = wr; busAddr = a; busWdata = d;
  endtask

  task automatic tick(string tag);
    logic [2:0] ns;
    @(posedge clk);
    ns = (busWr && busAddr == 4'd8) ? busWdata[2:0] : mNext(mState, condIn, cfgTable);
    mOut = mPat[mState];
    if (busWr && busAddr < 4'd8) mPat[busAddr[2:0]] = busWdata;
    mState = ns;
    @(negedge clk);
    chk(tag, "patternOut", patternOut, mOut);
    chk(tag, "busRdata", busRdata, mRead(busAddr));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1", "patternOut", patternOut, 8'h00);
    busAddr = 4'd8; #1; chk("R1", "state read", busRdata, 8'h00);
    busAddr = 4'd5; #1; chk("R1", "pattern read", busRdata, 8'h00);
    mState = '0; mOut = '0;
    for (int i = 0; i < 8; i++) mPat[i] = '0;
    @(negedge clk); rstN = 1'b1;

    // R3: write all pattern registers, read them back
    for (int i = 0; i < 8; i++) begin setBus(1, 4'(i), 8'hA0 + 8'(i)); tick("R3 write"); end
    for (int i = 0; i < 8; i++) begin setBus(0, 4'(i), 8'h00); tick("R3 read"); end

    // R4/R2: force state 5 with reserved bits set
    setBus(1, 4'd8, 8'hFD); tick("R4");
    setBus(0, 4'd8, 8'h00); #1;
    chk("R2", "state readback", busRdata, 8'h05);
    chk("R7", "out still old state", patternOut, 8'hA0);
    tick("R7"); chk("R7", "out of state 5", patternOut, 8'hA5);

    // R5: priority of entry 0 over entry 1 in state 5
    cfgTable[5*12 +: 12] = {6'b111_110, 6'b001_010};
    condIn = 8'h44; tick("R5");
    chk("R5", "entry0 priority", busRdata, 8'h01);
    // R6: stay when selected inputs are low
    condIn = 8'h00;
    repeat (3) tick("R6");
    chk("R6", "state held", busRdata, 8'h01);
    // R5: second entry alone
    setBus(1, 4'd8, 8'h05); tick("R5");
    setBus(0, 4'd8, 8'h00); condIn = 8'h40; tick("R5");
    chk("R5", "entry1 taken", busRdata, 8'h07);
    // R4: host write against a due transition in state 7
    condIn = 8'h45; setBus(1, 4'd8, 8'h03); tick("R4");
    setBus(0, 4'd8, 8'h00); condIn = 8'h00; #1;
    chk("R4", "host write wins", busRdata, 8'h03);

    // R8: unmapped addresses
    for (int a = 9; a < 16; a++) begin
      setBus(1, 4'(a), 8'hFF); tick("R8 write");
      setBus(0, 4'(a), 8'h00); #1;
      chk("R8", "unmapped read", busRdata, 8'h00);
    end
    for (int i = 0; i < 9; i++) begin setBus(0, 4'(i), 8'h00); tick("R8 no side effect"); end

    // random phases
    for (int p = 0; p < 4; p++) begin
      cfgTable = {$urandom, $urandom, $urandom};
      for (int k = 0; k < 400; k++) begin
        setBus(($urandom % 5) == 0, 4'($urandom % 16), 8'($urandom));
        condIn = 8'($urandom) & 8'($urandom) & 8'($urandom);
        tick("R5 random");
      end
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule